// File: doc/BRIEF.md
# Chained Control-Block DMA Channel

This block is one DMA channel that runs through a linked list of control blocks kept in memory. Software places an aligned block address in the channel's block-address register and sets RUN. The engine fetches the eight-word block with sequential reads, then copies the described number of 32-bit words from source to destination. It follows the block's link word to the next block and stops when that link is zero. Each side of the copy can advance its address per word or stay fixed, as when it points at a peripheral FIFO. Each side can also be held back by a selected peripheral data-request line.

The channel is idle exactly when the block-address register reads zero. Clearing RUN pauses the engine at the next request boundary. A status bit then shows whether write responses are still outstanding. A block may raise an interrupt when it finishes. If the last link points back to an earlier block, the chain repeats forever and the per-block interrupt marks each period. A zero-fill mode writes zeros without reading the source. A build-time variant limits the length of one block, and a read-only debug bit reports which variant was built.

Top module: `dma_chain_engine`

## Requirements
- R1: After reset the status register (select 0) and the block-address register (select 1) read 0, `irq` is low, and no memory request is issued.
- R2: When RUN is set and the block-address register is nonzero, the engine issues eight reads at the block address plus 0, 4, ... 28 before any data write. The words are info, source, destination, byte length, stride (unused) and link at word offsets 0 to 5.
- R3: A block moves ceil(length/4) words. Info bit 1 advances the source by 4 per word and info bit 2 advances the destination by 4 per word; when a bit is clear, that address stays fixed.
- R4: After a block completes, the engine loads the block named by the link word. A link of zero sets DONE (status bit 1), clears RUN (status bit 0) and makes the block-address register read 0.
- R5: A block whose info bit 0 is set raises IRQ (status bit 2, also the `irq` pin) after its last write. Writing 1 to a status bit 1 or 2 clears that bit. Writing 0x5 clears IRQ and keeps a looping chain running.
- R6: Info bits 12:8 select one request line of `dreq`. With info bit 3 set, each source read waits for that line to be high. With info bit 4 set, each destination write waits for it.
- R7: In the full variant, info bit 5 makes every data word zero, and no source reads are issued.
- R8: Writing RUN=0 stops new memory requests from the next cycle on. Status bit 3 is high while any write response is outstanding. Writing RUN=1 resumes from where the engine stopped.
- R9: A block length above the variant's maximum (LITE_MAX_LEN when LITE=1, FULL_MAX_LEN otherwise) is treated as that maximum.
- R10: Select 2 reads the LITE parameter in bit 0.
- R11: No more than MAX_OUT write responses are ever outstanding; the engine stalls its next write until one returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control/status, 1 block address, 2 debug |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data of the selected register |
| irq | output | 1 | Interrupt flag |
| dreq | input | NUM_DREQ | Peripheral data-request lines |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rd_valid | input | 1 | Read data return strobe |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | One-cycle write request |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data |
| mem_wr_resp | input | 1 | Write response strobe, one per write |

## Verification
The hardest state to reach is a pause while writes are still unacknowledged, with the outstanding limit reached at the same moment. The memory model in the bench can withhold write responses. The bench runs an eight-word block with responses held, waits until the engine stalls at the limit, and then clears RUN. It then checks that the waiting-for-writes bit is set and that no further request appears. Next it releases the responses and checks that the bit falls. Only then does it set RUN again and require the rest of the block to arrive in order.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;
  localparam int WORD_W   = 32;
  localparam int CB_WORDS = 8;
  localparam int MAP_W    = 5;

  // info word flag positions
  localparam int F_IRQ    = 0;
  localparam int F_SINC   = 1;
  localparam int F_DINC   = 2;
  localparam int F_SWAIT  = 3;
  localparam int F_DWAIT  = 4;
  localparam int F_ZERO   = 5;
  localparam int F_MAP_LO = 8;

  // register selects
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DBG  = 2'd2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_MOVE, SQ_NEXT} seq_t;

  typedef struct packed {
    logic [WORD_W-1:0] info;
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] len;
    logic [WORD_W-1:0] link;
  } blk_t;
endpackage

// File: rtl/dma_blk_loader.sv
module dma_blk_loader
  import dma_chain_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              en,
  input  logic [WORD_W-1:0] base,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              done,
  output blk_t              blk
);
  localparam int IDX_W = $clog2(CB_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CB_WORDS - 1);

  typedef enum logic [1:0] {L_IDLE, L_ISSUE, L_WAIT} ld_t;

  ld_t               st;
  logic [IDX_W-1:0]  idx;
  logic [WORD_W-1:0] base_q;
  logic [WORD_W-1:0] words [CB_WORDS];

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= L_IDLE;
      idx     <= '0;
      base_q  <= '0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      done    <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      done   <= 1'b0;
      case (st)
        L_IDLE: if (start) begin
          base_q <= base;
          idx    <= '0;
          st     <= L_ISSUE;
        end
        L_ISSUE: if (en) begin
          rd_req  <= 1'b1;
          rd_addr <= base_q + (WORD_W'(idx) << 2);
          st      <= L_WAIT;
        end
        L_WAIT: if (rd_valid) begin
          if (idx == LAST_IDX) begin
            done <= 1'b1;
            st   <= L_IDLE;
          end else begin
            idx <= idx + 1'b1;
            st  <= L_ISSUE;
          end
        end
        default: st <= L_IDLE;
      endcase
    end
  end

  // block word store, no reset so it maps to plain registers or RAM
  always_ff @(posedge clk) begin
    if (st == L_WAIT && rd_valid) words[idx] <= rd_data;
  end

  always_comb begin
    blk.info = words[0];
    blk.src  = words[1];
    blk.dst  = words[2];
    blk.len  = words[3];
    blk.link = words[5];
  end
endmodule

// File: rtl/dma_word_mover.sv
module dma_word_mover
  import dma_chain_pkg::*;
#(
  parameter int          NUM_DREQ     = 16,
  parameter bit          LITE         = 1'b0,
  parameter logic [31:0] LITE_MAX_LEN = 32'd65532,
  parameter logic [31:0] FULL_MAX_LEN = 32'h4000_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                en,
  input  blk_t                blk,
  input  logic [NUM_DREQ-1:0] dreq,
  output logic                rd_req,
  output logic [WORD_W-1:0]   rd_addr,
  input  logic                rd_valid,
  input  logic [WORD_W-1:0]   rd_data,
  input  logic                full,
  output logic                wr_req,
  output logic [WORD_W-1:0]   wr_addr,
  output logic [WORD_W-1:0]   wr_data,
  output logic                done
);
  localparam logic [31:0] MAX_LEN = LITE ? LITE_MAX_LEN : FULL_MAX_LEN;

  typedef enum logic [1:0] {M_IDLE, M_RD, M_RWAIT, M_WR} mv_t;

  mv_t               st;
  logic [WORD_W-1:0] src_q, dst_q, data_q, cnt;
  logic [MAP_W-1:0]  map_q;
  logic              sinc_q, dinc_q, swait_q, dwait_q, zero_q;
  logic [WORD_W-1:0] len_c, nwords;
  logic              dreq_sel;

  always_comb begin
    len_c  = (blk.len > MAX_LEN) ? MAX_LEN : blk.len;
    nwords = (len_c + 32'd3) >> 2;
  end

  always_comb begin
    dreq_sel = 1'b0;
    for (int i = 0; i < NUM_DREQ; i++)
      if (map_q == MAP_W'(i)) dreq_sel = dreq[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= M_IDLE;
      src_q   <= '0;
      dst_q   <= '0;
      data_q  <= '0;
      cnt     <= '0;
      map_q   <= '0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      swait_q <= 1'b0;
      dwait_q <= 1'b0;
      zero_q  <= 1'b0;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      done    <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      wr_req <= 1'b0;
      done   <= 1'b0;
      case (st)
        M_IDLE: if (start) begin
          src_q   <= blk.src;
          dst_q   <= blk.dst;
          cnt     <= nwords;
          map_q   <= blk.info[F_MAP_LO +: MAP_W];
          sinc_q  <= blk.info[F_SINC];
          dinc_q  <= blk.info[F_DINC];
          swait_q <= blk.info[F_SWAIT];
          dwait_q <= blk.info[F_DWAIT];
          zero_q  <= blk.info[F_ZERO] && !LITE;
          if (nwords == '0) done <= 1'b1;
          else              st   <= M_RD;
        end
        M_RD: if (en && (!swait_q || dreq_sel)) begin
          if (zero_q) begin
            data_q <= '0;
            st     <= M_WR;
          end else begin
            rd_req  <= 1'b1;
            rd_addr <= src_q;
            st      <= M_RWAIT;
          end
        end
        M_RWAIT: if (rd_valid) begin
          data_q <= rd_data;
          st     <= M_WR;
        end
        M_WR: if (en && !full && (!dwait_q || dreq_sel)) begin
          wr_req  <= 1'b1;
          wr_addr <= dst_q;
          wr_data <= data_q;
          if (sinc_q) src_q <= src_q + 32'd4;
          if (dinc_q) dst_q <= dst_q + 32'd4;
          cnt <= cnt - 1'b1;
          if (cnt == 32'd1) begin
            done <= 1'b1;
            st   <= M_IDLE;
          end else begin
            st <= M_RD;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  // R6: a gated write only follows a cycle with the selected request line high
  a_r6_dst_gate: assert property (@(posedge clk) disable iff (rst)
    (wr_req && dwait_q) |-> $past(dreq_sel));

  // R7: zero-fill blocks never read the source
  a_r7_no_src_read: assert property (@(posedge clk) disable iff (rst)
    zero_q |-> !rd_req);
endmodule

// File: rtl/dma_wr_tracker.sv
module dma_wr_tracker #(
  parameter int MAX_OUT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic resp,
  output logic busy,
  output logic full
);
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(MAX_OUT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else begin
      case ({issue, resp})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   if (cnt != '0) cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign busy = (cnt != '0);
  assign full = (cnt == LIMIT);

  // R11: the write issuer never pushes past the outstanding limit
  a_r11_no_overflow: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIMIT);
endmodule

// File: rtl/dma_chain_engine.sv
module dma_chain_engine
  import dma_chain_pkg::*;
#(
  parameter int          NUM_DREQ     = 16,
  parameter int          MAX_OUT      = 4,
  parameter bit          LITE         = 1'b0,
  parameter logic [31:0] LITE_MAX_LEN = 32'd65532,
  parameter logic [31:0] FULL_MAX_LEN = 32'h4000_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                reg_we,
  input  logic [1:0]          reg_sel,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  output logic                irq,
  input  logic [NUM_DREQ-1:0] dreq,
  output logic                mem_rd_req,
  output logic [31:0]         mem_rd_addr,
  input  logic                mem_rd_valid,
  input  logic [31:0]         mem_rd_data,
  output logic                mem_wr_req,
  output logic [31:0]         mem_wr_addr,
  output logic [31:0]         mem_wr_data,
  input  logic                mem_wr_resp
);
  localparam int ALIGN_B = $clog2(CB_WORDS * 4);

  seq_t              seq;
  logic              run_q, done_q, irq_q;
  logic [WORD_W-1:0] cur_addr, link_al, ld_base;
  logic              ctrl_wr, addr_wr;
  logic              start_ld, start_mv, ld_done, mv_done;
  logic              ld_rd_req, mv_rd_req;
  logic [WORD_W-1:0] ld_rd_addr, mv_rd_addr;
  logic              wr_busy, wr_full;
  blk_t              blk;

  assign ctrl_wr  = reg_we && (reg_sel == SEL_CTRL);
  assign addr_wr  = reg_we && (reg_sel == SEL_ADDR);
  assign link_al  = {blk.link[WORD_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
  assign start_ld = (seq == SQ_IDLE && run_q && cur_addr != '0) ||
                    (seq == SQ_NEXT && blk.link != '0);
  assign ld_base  = (seq == SQ_NEXT) ? link_al : cur_addr;
  assign start_mv = (seq == SQ_LOAD) && ld_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq      <= SQ_IDLE;
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      irq_q    <= 1'b0;
      cur_addr <= '0;
    end else begin
      if (ctrl_wr) begin
        if (reg_wdata[1]) done_q <= 1'b0;
        if (reg_wdata[2]) irq_q  <= 1'b0;
      end
      case (seq)
        SQ_IDLE: begin
          if (addr_wr) cur_addr <= {reg_wdata[WORD_W-1:ALIGN_B], {ALIGN_B{1'b0}}};
          if (run_q && cur_addr != '0) seq <= SQ_LOAD;
        end
        SQ_LOAD: if (ld_done) seq <= SQ_MOVE;
        SQ_MOVE: if (mv_done) begin
          if (blk.info[F_IRQ]) irq_q <= 1'b1;
          seq <= SQ_NEXT;
        end
        SQ_NEXT: begin
          cur_addr <= link_al;
          if (blk.link == '0) begin
            done_q <= 1'b1;
            seq    <= SQ_IDLE;
          end else begin
            seq <= SQ_LOAD;
          end
        end
        default: seq <= SQ_IDLE;
      endcase
      if (ctrl_wr)                                run_q <= reg_wdata[0];
      else if (seq == SQ_NEXT && blk.link == '0)  run_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else begin
      case (reg_sel)
        SEL_CTRL: reg_rdata <= {28'd0, wr_busy, irq_q, done_q, run_q};
        SEL_ADDR: reg_rdata <= cur_addr;
        SEL_DBG:  reg_rdata <= {31'd0, LITE};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  assign irq = irq_q;

  dma_blk_loader u_loader (
    .clk      (clk),
    .rst      (rst),
    .start    (start_ld),
    .en       (run_q),
    .base     (ld_base),
    .rd_req   (ld_rd_req),
    .rd_addr  (ld_rd_addr),
    .rd_valid (mem_rd_valid),
    .rd_data  (mem_rd_data),
    .done     (ld_done),
    .blk      (blk)
  );

  dma_word_mover #(
    .NUM_DREQ     (NUM_DREQ),
    .LITE         (LITE),
    .LITE_MAX_LEN (LITE_MAX_LEN),
    .FULL_MAX_LEN (FULL_MAX_LEN)
  ) u_mover (
    .clk      (clk),
    .rst      (rst),
    .start    (start_mv),
    .en       (run_q),
    .blk      (blk),
    .dreq     (dreq),
    .rd_req   (mv_rd_req),
    .rd_addr  (mv_rd_addr),
    .rd_valid (mem_rd_valid),
    .rd_data  (mem_rd_data),
    .full     (wr_full),
    .wr_req   (mem_wr_req),
    .wr_addr  (mem_wr_addr),
    .wr_data  (mem_wr_data),
    .done     (mv_done)
  );

  dma_wr_tracker #(.MAX_OUT(MAX_OUT)) u_track (
    .clk   (clk),
    .rst   (rst),
    .issue (mem_wr_req),
    .resp  (mem_wr_resp),
    .busy  (wr_busy),
    .full  (wr_full)
  );

  assign mem_rd_req  = ld_rd_req | mv_rd_req;
  assign mem_rd_addr = ld_rd_req ? ld_rd_addr : mv_rd_addr;

  // R8: with RUN clear, neither side starts a request in the following cycle
  a_r8_no_wr_paused: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !mem_wr_req);
  a_r8_no_rd_paused: assert property (@(posedge clk) disable iff (rst)
    !run_q |=> !mem_rd_req);

  // R4: the end of a chain always leaves the block address at zero
  a_r4_end_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (cur_addr == '0));

  // R3: loader, mover reads and writes never collide on the memory port
  a_r3_one_req: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ld_rd_req, mv_rd_req, mem_wr_req}));
endmodule

// File: tb/test_dma_chain_engine.sv
module test_dma_chain_engine;
  localparam int NUM_DREQ = 16;
  localparam int CLAMP    = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic [NUM_DREQ-1:0] dreq = '0;
  logic        mem_rd_req, mem_wr_req;
  logic [31:0] mem_rd_addr, mem_wr_addr, mem_wr_data;
  logic        mem_rd_valid = 1'b0, mem_wr_resp = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #4 clk = ~clk;

  dma_chain_engine #(
    .NUM_DREQ(NUM_DREQ), .MAX_OUT(4), .LITE(1'b0),
    .FULL_MAX_LEN(32'(CLAMP))
  ) i_dma_chain_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .dreq(dreq),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_wr_resp(mem_wr_resp)
  );

  typedef struct { logic [31:0] a; logic [31:0] d; } exp_t;
  exp_t        sbq[$];
  logic [31:0] mem [1024];
  logic [31:0] rd_log [64];
  int n_chk = 0, n_fail = 0, cyc = 0;
  int rd_count = 0, wr_count = 0, first_wr_rd = -1, pend = 0;
  bit hold = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // memory model: answers reads one cycle later, can withhold write responses
  always @(negedge clk) begin
    if (rst) begin
      mem_rd_valid = 1'b0;
      mem_wr_resp  = 1'b0;
      pend         = 0;
    end else begin
      mem_rd_valid = mem_rd_req;
      if (mem_rd_req) mem_rd_data = mem[mem_rd_addr[11:2]];
      if (pend > 0 && !hold) begin
        mem_wr_resp = 1'b1;
        pend--;
      end else begin
        mem_wr_resp = 1'b0;
      end
      if (mem_wr_req) begin
        mem[mem_wr_addr[11:2]] = mem_wr_data;
        pend++;
      end
    end
  end

  // monitor: logs reads, pops the scoreboard on every write
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      finish_run();
    end
    if (!rst) begin
      if (mem_rd_req) begin
        if (rd_count < 64) rd_log[rd_count] = mem_rd_addr;
        rd_count++;
      end
      if (mem_wr_req) begin
        if (first_wr_rd < 0) first_wr_rd = rd_count;
        wr_count++;
        if (sbq.size() == 0) begin
          check(1'b0, "R3 unexpected write addr", mem_wr_addr, 32'hffff_ffff);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          check(mem_wr_addr == e.a, "R3 write address", mem_wr_addr, e.a);
          check(mem_wr_data == e.d, "R3/R7 write data", mem_wr_data, e.d);
        end
      end
    end
  end

  task automatic wr_reg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] sel, output logic [31:0] v);
    @(negedge clk);
    reg_sel = sel;
    @(negedge clk);
    v = reg_rdata;
  endtask

  task automatic put_cb(input int addr, input logic [31:0] info, src, dst, len, link);
    mem[(addr >> 2) + 0] = info;
    mem[(addr >> 2) + 1] = src;
    mem[(addr >> 2) + 2] = dst;
    mem[(addr >> 2) + 3] = len;
    mem[(addr >> 2) + 4] = 32'h0;
    mem[(addr >> 2) + 5] = link;
  endtask

  // driver: pushes the writes a block must produce, worked out from the requirements
  task automatic expect_blk(input logic [31:0] info, src, dst, len);
    int l, n;
    l = (len > CLAMP) ? CLAMP : int'(len);
    n = (l + 3) / 4;
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.a = dst + (info[2] ? 32'(4 * i) : 32'd0);
      e.d = info[5] ? 32'd0 : mem[(src + (info[1] ? 32'(4 * i) : 32'd0)) >> 2];
      sbq.push_back(e);
    end
  endtask

  task automatic clear_counts();
    rd_count = 0; wr_count = 0; first_wr_rd = -1;
  endtask

  task automatic start_at(input logic [31:0] a);
    wr_reg(2'd1, a);
    wr_reg(2'd0, 32'h1);
  endtask

  task automatic wait_done(input string tag);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 3000 && !v[1]; i++) rd_reg(2'd0, v);
    check(v[1] == 1'b1, tag, v, 32'h2);
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 3000 && !irq; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    logic [31:0] v;
    int snap;
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    for (int i = 0; i < 64; i++) mem[256 + i] = 32'hA500_0000 + 32'(i * 17);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state, R10 debug bit
    rd_reg(2'd0, v); check(v == 32'h0, "R1 status after reset", v, 32'h0);
    rd_reg(2'd1, v); check(v == 32'h0, "R1 block address after reset", v, 32'h0);
    check(irq == 1'b0, "R1 irq after reset", 32'(irq), 32'h0);
    check(rd_count == 0 && wr_count == 0, "R1 no requests", 32'(rd_count + wr_count), 32'h0);
    rd_reg(2'd2, v); check(v == 32'h0, "R10 debug lite bit", v, 32'h0);

    // R2 R3 R4 R5: single block, both addresses increment, interrupt enabled
    clear_counts();
    put_cb(32'h100, 32'h7, 32'h400, 32'h800, 32'd16, 32'h0);
    expect_blk(32'h7, 32'h400, 32'h800, 32'd16);
    start_at(32'h100);
    wait_done("R4 single block done");
    for (int k = 0; k < 8; k++)
      check(rd_log[k] == 32'h100 + 32'(4 * k), "R2 block word read", rd_log[k], 32'h100 + 32'(4 * k));
    check(first_wr_rd == 9, "R2 reads before first write", 32'(first_wr_rd), 32'd9);
    check(sbq.size() == 0, "R3 all writes seen", 32'(sbq.size()), 32'h0);
    rd_reg(2'd0, v); check(v == 32'h6, "R4 R5 status at end", v, 32'h6);
    rd_reg(2'd1, v); check(v == 32'h0, "R4 block address idle", v, 32'h0);
    check(irq == 1'b1, "R5 irq pin set", 32'(irq), 32'h1);
    wr_reg(2'd0, 32'h6);
    rd_reg(2'd0, v); check(v == 32'h0, "R5 write-one clears", v, 32'h0);
    check(irq == 1'b0, "R5 irq pin cleared", 32'(irq), 32'h0);

    // R3 R4: two-block chain, odd length, fixed destination in second block
    clear_counts();
    put_cb(32'h100, 32'h6, 32'h400, 32'h800, 32'd10, 32'h120);
    put_cb(32'h120, 32'h2, 32'h410, 32'h900, 32'd8, 32'h0);
    expect_blk(32'h6, 32'h400, 32'h800, 32'd10);
    expect_blk(32'h2, 32'h410, 32'h900, 32'd8);
    start_at(32'h100);
    wait_done("R4 chain done");
    check(sbq.size() == 0, "R3 chain writes seen", 32'(sbq.size()), 32'h0);
    check(rd_count == 21, "R4 chain read count", 32'(rd_count), 32'd21);
    check(irq == 1'b0, "R5 no irq without flag", 32'(irq), 32'h0);
    wr_reg(2'd0, 32'h6);

    // R7: zero fill, no source reads
    clear_counts();
    put_cb(32'h140, 32'h26, 32'h400, 32'hA00, 32'd12, 32'h0);
    expect_blk(32'h26, 32'h400, 32'hA00, 32'd12);
    start_at(32'h140);
    wait_done("R7 zero block done");
    check(sbq.size() == 0, "R7 zero writes seen", 32'(sbq.size()), 32'h0);
    check(rd_count == 8, "R7 only block reads", 32'(rd_count), 32'd8);
    wr_reg(2'd0, 32'h6);

    // R6: destination gated by line 2
    clear_counts();
    put_cb(32'h100, 32'h216, 32'h400, 32'hA40, 32'd8, 32'h0);
    expect_blk(32'h216, 32'h400, 32'hA40, 32'd8);
    start_at(32'h100);
    repeat (50) @(negedge clk);
    check(wr_count == 0, "R6 write held by request line", 32'(wr_count), 32'h0);
    rd_reg(2'd1, v); check(v == 32'h100, "R6 channel still busy", v, 32'h100);
    dreq[2] = 1'b1;
    wait_done("R6 gated block done");
    check(sbq.size() == 0, "R6 writes after request", 32'(sbq.size()), 32'h0);
    dreq = '0;
    wr_reg(2'd0, 32'h6);

    // R6: source gated by line 3
    clear_counts();
    put_cb(32'h100, 32'h30E, 32'h420, 32'hA80, 32'd8, 32'h0);
    expect_blk(32'h30E, 32'h420, 32'hA80, 32'd8);
    start_at(32'h100);
    repeat (50) @(negedge clk);
    check(rd_count == 8, "R6 source read held", 32'(rd_count), 32'd8);
    dreq[3] = 1'b1;
    wait_done("R6 source gated done");
    check(sbq.size() == 0, "R6 source gated writes", 32'(sbq.size()), 32'h0);
    dreq = '0;
    wr_reg(2'd0, 32'h6);

    // R8 R11: pause with responses withheld and the limit reached
    clear_counts();
    hold = 1'b1;
    put_cb(32'h100, 32'h6, 32'h400, 32'hC00, 32'd32, 32'h0);
    expect_blk(32'h6, 32'h400, 32'hC00, 32'd32);
    start_at(32'h100);
    repeat (80) @(negedge clk);
    check(wr_count == 4, "R11 stall at outstanding limit", 32'(wr_count), 32'd4);
    wr_reg(2'd0, 32'h0);
    rd_reg(2'd0, v); check(v == 32'h8, "R8 paused with writes pending", v, 32'h8);
    hold = 1'b0;
    repeat (20) @(negedge clk);
    rd_reg(2'd0, v); check(v == 32'h0, "R8 pending bit falls", v, 32'h0);
    snap = wr_count;
    check(snap == 4, "R8 no writes while paused", 32'(snap), 32'd4);
    wr_reg(2'd0, 32'h1);
    wait_done("R8 resumed block done");
    check(sbq.size() == 0, "R8 remaining writes in order", 32'(sbq.size()), 32'h0);
    wr_reg(2'd0, 32'h6);

    // R5: looping chain, clear IRQ while running
    clear_counts();
    put_cb(32'h160, 32'h3, 32'h440, 32'hB00, 32'd8, 32'h160);
    expect_blk(32'h3, 32'h440, 32'hB00, 32'd8);
    expect_blk(32'h3, 32'h440, 32'hB00, 32'd8);
    start_at(32'h160);
    wait_irq();
    check(irq == 1'b1, "R5 first period irq", 32'(irq), 32'h1);
    wr_reg(2'd0, 32'h5);
    rd_reg(2'd0, v); check(v[2:0] == 3'b001, "R5 irq cleared run kept", v, 32'h1);
    wait_irq();
    wr_reg(2'd0, 32'h4);
    repeat (40) @(negedge clk);
    check(wr_count == 4, "R5 two periods of writes", 32'(wr_count), 32'd4);
    check(sbq.size() == 0, "R5 looping writes seen", 32'(sbq.size()), 32'h0);
    rd_reg(2'd1, v); check(v == 32'h160, "R8 paused chain keeps address", v, 32'h160);
    do_reset();

    // R9: length above the maximum is clamped
    clear_counts();
    put_cb(32'h100, 32'h6, 32'h400, 32'hD00, 32'd100, 32'h0);
    expect_blk(32'h6, 32'h400, 32'hD00, 32'd100);
    start_at(32'h100);
    wait_done("R9 clamped block done");
    check(wr_count == CLAMP / 4, "R9 clamped word count", 32'(wr_count), 32'(CLAMP / 4));
    check(sbq.size() == 0, "R9 clamped writes seen", 32'(sbq.size()), 32'h0);

    finish_run();
  end
endmodule